// File: doc/BRIEF.md
# Scaled saturating pack unit

This block narrows fixed-point lanes held in a 64-bit operand into smaller lanes. Each lane is first scaled up by a left shift whose amount is read from a small field of a 64-bit graphics status word, then shifted right arithmetically to drop a fixed number of fraction bits. The result is then clamped to the range of the narrower destination lane. The right shift and the clamp range are fixed for each operation.

A 2-bit operation code selects one of three operations:
- **Byte pack from halfwords:** four signed 16-bit lanes become four unsigned bytes.
- **Byte merge from words:** two signed 32-bit lanes become unsigned bytes, which are merged into a byte-shifted copy of a second operand.
- **Halfword pack from words:** two signed 32-bit lanes become two signed halfwords.

Results that are only 32 bits wide are zero-extended to 64 bits. A request is presented with `in_valid`. The registered result appears one clock later together with `out_valid`.

Top module: `pack_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 after any cycle with `in_valid` low.
- R3: When `in_valid` is low, `result` keeps its previous value, whatever `op`, `gsr`, `rs1` and `rs2` do.
- R4: For op 0, the scale is the 4-bit value `gsr[6:3]`. For ops 1 and 2, the scale is the 5-bit value `gsr[7:3]`.
- R5: For op 0, each signed halfword lane k of `rs2` (bits [16k+15:16k]) is shifted left by the scale without loss, then arithmetically right by 7, then clamped to 0..255. The clamped value goes to `result[8k+7:8k]`, and `result[63:32]` is zero.
- R6: For op 1, the result is `rs1` shifted left by 8 bits, with bits [7:0] and [39:32] replaced by the packed bytes. All other bits come from the shifted `rs1`.
- R7: For op 1, each signed word lane w of `rs2` (bits [32w+31:32w]) is shifted left by the scale at 64-bit precision, then arithmetically right by 23, then clamped to 0..255. The clamped value goes to `result[32w+7:32w]`.
- R8: For op 2, each signed word lane w of `rs2` is shifted left by the scale at 64-bit precision, then arithmetically right by 16, then clamped to -32768..32767. The value goes to `result[16w+15:16w]` in two's complement, and `result[63:32]` is zero.
- R9: For op 3, the result is all zeros.
- R10: `gsr` bits outside the scale field have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; inputs are captured when high |
| op | input | 2 | Operation: 0 halfword-to-byte, 1 word-to-byte merge, 2 word-to-halfword, 3 zero |
| gsr | input | 64 | Status word carrying the scale field |
| rs1 | input | 64 | Merge base operand for op 1 |
| rs2 | input | 64 | Lanes to be packed |
| out_valid | output | 1 | High in the cycle after a request |
| result | output | 64 | Registered packed result |

## Verification
The bench builds the block with its default parameters: the scale field sits at bit 3, and the scale widths are 4 and 5 bits. With these values, every scale value from 0 to the maximum of 15 or 31 can be reached by random `gsr` words. The upper `gsr` bits are randomised too, so any leak of bit 7 into the halfword path, or of other bits into any path, shows up as a mismatch. Directed cases drive the largest positive and negative lanes at the maximum scale, which reaches both clamp bounds of every operation and the widest intermediate values.

// File: rtl/pack_pkg.sv
`timescale 1ns/1ps
package pack_pkg;
    localparam int DATA_W   = 64;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int N_HALF   = DATA_W / HALF_W;
    localparam int N_WORD   = DATA_W / WORD_W;
    localparam int FRAC_H2B = 7;
    localparam int FRAC_W2B = 23;
    localparam int FRAC_W2H = 16;
    localparam int WIDE_H   = 48;
    localparam int WIDE_W   = 64;

    typedef enum logic [1:0] {
        OP_H2B  = 2'd0,
        OP_W2B  = 2'd1,
        OP_W2H  = 2'd2,
        OP_ZERO = 2'd3
    } pack_op_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
    } pack_state_t;
endpackage

// File: rtl/pack_lane.sv
`timescale 1ns/1ps
module pack_lane #(
    parameter int IN_W       = 16,
    parameter int SCALE_W    = 4,
    parameter int FRAC       = 7,
    parameter int OUT_W      = 8,
    parameter bit SIGNED_OUT = 1'b0,
    parameter int WIDE       = 48
) (
    input  logic [IN_W-1:0]    lane_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [OUT_W-1:0]   packed_o
);
    localparam logic signed [WIDE-1:0] ONE = 1;
    localparam logic signed [WIDE-1:0] HI  = SIGNED_OUT ? (ONE <<< (OUT_W-1)) - ONE
                                                        : (ONE <<< OUT_W) - ONE;
    localparam logic signed [WIDE-1:0] LO  = SIGNED_OUT ? -(ONE <<< (OUT_W-1)) : '0;

    logic signed [WIDE-1:0] ext;
    logic signed [WIDE-1:0] scaled;
    logic signed [WIDE-1:0] fixed;
    logic signed [WIDE-1:0] clamped;

    always_comb begin
        ext    = {{(WIDE-IN_W){lane_i[IN_W-1]}}, lane_i};
        scaled = ext <<< scale_i;
        fixed  = scaled >>> FRAC;
        if (fixed < LO)      clamped = LO;
        else if (fixed > HI) clamped = HI;
        else                 clamped = fixed;
        packed_o = clamped[OUT_W-1:0];
    end
endmodule

// File: rtl/pack_assemble.sv
`timescale 1ns/1ps
module pack_assemble
    import pack_pkg::*;
(
    input  logic [1:0]                     op_i,
    input  logic [DATA_W-1:0]              rs1_i,
    input  logic [N_HALF-1:0][BYTE_W-1:0]  h2b_i,
    input  logic [N_WORD-1:0][BYTE_W-1:0]  w2b_i,
    input  logic [N_WORD-1:0][HALF_W-1:0]  w2h_i,
    output logic [DATA_W-1:0]              result_o
);
    logic [DATA_W-1:0] merge_base;
    logic [DATA_W-1:0] merge_bytes;

    always_comb begin
        merge_base  = rs1_i << BYTE_W;
        merge_bytes = '0;
        for (int w = 0; w < N_WORD; w++) begin
            merge_base[w*WORD_W +: BYTE_W]  = '0;
            merge_bytes[w*WORD_W +: BYTE_W] = w2b_i[w];
        end
        case (pack_op_e'(op_i))
            OP_H2B:  result_o = {{(DATA_W-N_HALF*BYTE_W){1'b0}}, h2b_i};
            OP_W2B:  result_o = merge_base | merge_bytes;
            OP_W2H:  result_o = {{(DATA_W-N_WORD*HALF_W){1'b0}}, w2h_i};
            default: result_o = '0;
        endcase
    end
endmodule

// File: rtl/pack_unit.sv
`timescale 1ns/1ps
module pack_unit
    import pack_pkg::*;
#(
    parameter int SCALE_LSB = 3,
    parameter int SHORT_SW  = 4,
    parameter int LONG_SW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] gsr,
    input  logic [DATA_W-1:0] rs1,
    input  logic [DATA_W-1:0] rs2,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int LONG_MSB = SCALE_LSB + LONG_SW - 1;

    logic [SHORT_SW-1:0] scale_short;
    logic [LONG_SW-1:0]  scale_long;
    logic [N_HALF-1:0][BYTE_W-1:0] h2b;
    logic [N_WORD-1:0][BYTE_W-1:0] w2b;
    logic [N_WORD-1:0][HALF_W-1:0] w2h;
    logic [DATA_W-1:0] packed_res;
    logic unused_gsr;

    pack_state_t st_d, st_q;

    assign scale_short = gsr[SCALE_LSB +: SHORT_SW];
    assign scale_long  = gsr[SCALE_LSB +: LONG_SW];
    assign unused_gsr  = ^{gsr[DATA_W-1:LONG_MSB+1], gsr[SCALE_LSB-1:0]};

    for (genvar k = 0; k < N_HALF; k++) begin : g_h2b
        pack_lane #(.IN_W(HALF_W), .SCALE_W(SHORT_SW), .FRAC(FRAC_H2B),
                    .OUT_W(BYTE_W), .SIGNED_OUT(1'b0), .WIDE(WIDE_H)) u_lane (
            .lane_i(rs2[k*HALF_W +: HALF_W]), .scale_i(scale_short), .packed_o(h2b[k]));
    end

    for (genvar w = 0; w < N_WORD; w++) begin : g_word
        pack_lane #(.IN_W(WORD_W), .SCALE_W(LONG_SW), .FRAC(FRAC_W2B),
                    .OUT_W(BYTE_W), .SIGNED_OUT(1'b0), .WIDE(WIDE_W)) u_byte (
            .lane_i(rs2[w*WORD_W +: WORD_W]), .scale_i(scale_long), .packed_o(w2b[w]));
        pack_lane #(.IN_W(WORD_W), .SCALE_W(LONG_SW), .FRAC(FRAC_W2H),
                    .OUT_W(HALF_W), .SIGNED_OUT(1'b1), .WIDE(WIDE_W)) u_half (
            .lane_i(rs2[w*WORD_W +: WORD_W]), .scale_i(scale_long), .packed_o(w2h[w]));
    end

    pack_assemble u_asm (
        .op_i(op), .rs1_i(rs1), .h2b_i(h2b), .w2b_i(w2b), .w2h_i(w2h),
        .result_o(packed_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.result = packed_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R5
    h2b_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0) |=> result[63:32] == '0);
    // R6
    w2b_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd1) |=> (result[31:8] == $past(rs1[23:0]) &&
                                      result[63:40] == $past(rs1[55:32])));
    // R8
    w2h_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd2) |=> result[63:32] == '0);
    // R9
    zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd3) |=> result == '0);
endmodule

// File: tb/sim_pack_unit.sv
`timescale 1ns/1ps
module sim_pack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [63:0] gsr = '0, rs1 = '0, rs2 = '0;
    logic        out_valid;
    logic [63:0] result;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    pack_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .gsr(gsr),
                  .rs1(rs1), .rs2(rs2), .out_valid(out_valid), .result(result));

    function automatic longint lane_pack(longint src, int sc, int frac, longint lo, longint hi);
        longint v;
        v = (src <<< sc) >>> frac;
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return v;
    endfunction

    function automatic logic [63:0] model(logic [1:0] o, logic [63:0] g, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        longint v;
        r = '0;
        case (o)
            2'd0: for (int k = 0; k < 4; k++) begin   // R4 R5
                v = lane_pack(longint'($signed(b[16*k +: 16])), int'(g[6:3]), 7, 0, 255);
                r[8*k +: 8] = v[7:0];
            end
            2'd1: begin                               // R6 R7
                r = a << 8;
                for (int w = 0; w < 2; w++) begin
                    v = lane_pack(longint'($signed(b[32*w +: 32])), int'(g[7:3]), 23, 0, 255);
                    r[32*w +: 8] = v[7:0];
                end
            end
            2'd2: for (int w = 0; w < 2; w++) begin   // R8
                v = lane_pack(longint'($signed(b[32*w +: 32])), int'(g[7:3]), 16, -32768, 32767);
                r[16*w +: 16] = v[15:0];
            end
            default: r = '0;                          // R9
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(string req, logic [1:0] o, logic [63:0] g, logic [63:0] a, logic [63:0] b);
        logic [63:0] exp;
        exp = model(o, g, a, b);
        @(negedge clk);
        in_valid = 1'b1; op = o; gsr = g; rs1 = a; rs2 = b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {63'd0, out_valid}, 64'd1);
        check(req, result, exp);
        op = ~o; gsr = ~g; rs1 = ~a; rs2 = ~b;
        @(negedge clk);
        check("R2 idle", {63'd0, out_valid}, 64'd0);
        check("R3 hold", result, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {63'd0, out_valid} | result, 64'd0);

        // directed corners: maximum scale, extreme lanes
        run_op("R5 clamp hi/lo", 2'd0, 64'h78, 64'd0, 64'h8000_7fff_0080_ff80);
        run_op("R4 bit7 ignored", 2'd0, 64'hFFFF_FFFF_FFFF_FF80, 64'd0, 64'h0100_0200_7fff_8000);
        run_op("R7 clamp", 2'd1, 64'hF8, 64'h1122_3344_5566_7788, 64'h8000_0000_7fff_ffff);
        run_op("R6 base", 2'd1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000);
        run_op("R8 clamp", 2'd2, 64'hF8, 64'd0, 64'h8000_0000_7fff_ffff);
        run_op("R8 small", 2'd2, 64'h0, 64'd0, 64'hFFFF_0000_0001_8000);
        run_op("R9 zero op", 2'd3, 64'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R10 other gsr bits", 2'd2, 64'hA5A5_A5A5_A5A5_A507, 64'd0, 64'h0012_3456_FFED_CBA9);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] g, a, b;
            g = {$urandom, $urandom};
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            case (i % 4)
                0: run_op("R5 random", 2'd0, g, a, b);
                1: run_op("R7 random", 2'd1, g, a, b);
                2: run_op("R8 random", 2'd2, g, a, b);
                default: run_op("R10 random", 2'($urandom % 3), g, a, b);
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule